// File: doc/BRIEF.md
# Dual-Mode Pixel Input Capture

This block takes a parallel RGB pixel interface into the chip and turns it into one 24-bit pixel per internal pixel-clock cycle for a downstream link encoder. The input side consists of two 24-bit pixel buses, a data-enable, horizontal and vertical sync, three general-purpose control bits, and three static straps. One strap picks the input-clock edge used for sampling. One picks single- or dual-pixel words. The third is an active-low power-down.

In single-pixel mode the internal pixel clock is the input clock, and only the first bus carries data. In dual-pixel mode the internal pixel clock runs at twice the input rate, with its rising edges aligned to the input clock's edges. Each captured word is then emitted as two pixels: the first bus, then the second. Both pixels carry the data-enable, sync and control values that were sampled with that word. A capture on either input-clock edge is moved into the rising-edge pixel domain through one retiming register, so the latency is the same in every mode. The reset input is asynchronous and active-low, and it is expected to be released synchronously to the pixel clock.

Top module: `pixin_capture`

## Requirements
- R1: With `edge_rise` = 1, all pixel, enable, sync and control inputs are sampled on the rising edge of `clk_in`.
- R2: With `edge_rise` = 0, all those inputs are sampled on the falling edge of `clk_in`.
- R3: The output beat for a word captured on a given `clk_in` edge is updated on the second rising `clk_pix` edge after that capture edge. This holds in both edge modes and both pixel modes.
- R4: With `dual_px` = 0, each captured word produces one output beat with `px_out` = `px_first`. The value on `px_second` has no effect on any output.
- R5: With `dual_px` = 1, each captured word produces two beats on consecutive `clk_pix` cycles: `px_first`, then `px_second`.
- R6: In dual mode, both beats of a word carry the `de_in`, `hs_in`, `vs_in` and `ctl_in` values sampled with that word.
- R7: While `pd_n` = 0, nothing is captured, and from the next `clk_pix` edge on, every output is held at 0.
- R8: After `pd_n` returns to 1, `de_out` stays 0 and all outputs stay idle (0) until a word captured after the release reaches the output. No word captured before power-down is ever emitted.
- R9: While `rst_n` = 0, every output is 0.
- R10: Sync and control values pass through unchanged during blanking (`de_in` = 0), with the same timing as during active pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input data clock |
| clk_pix | input | 1 | Internal pixel clock (equal to `clk_in`, or twice its rate in dual mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down, active low |
| edge_rise | input | 1 | Capture edge strap: 1 = rising, 0 = falling |
| dual_px | input | 1 | Pixel mode strap: 1 = two pixels per input clock |
| px_first | input | 24 | First pixel of each word |
| px_second | input | 24 | Second pixel of each word (dual mode only) |
| de_in | input | 1 | Data enable, high during active pixels |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| ctl_in | input | 3 | General-purpose control bits |
| px_out | output | 24 | Output pixel |
| de_out | output | 1 | Output data enable |
| hs_out | output | 1 | Output horizontal sync |
| vs_out | output | 1 | Output vertical sync |
| ctl_out | output | 3 | Output control bits |

## Verification
The checker watches four things on every cycle. It confirms that outputs go idle one edge after power-down is seen. It confirms that the control bundle does not change between the two beats of a dual word. It confirms that new words in dual mode arrive at most every other pixel cycle. It confirms that `de_out` is never raised without a freshly retimed word behind it.

Some properties can only be shown by the bench scenarios, because they depend on the values on the buses:
- the capture edge, which shows up when data changes between the two clock edges;
- the exact two-edge latency;
- the first-then-second pixel order;
- the ignored second bus in single mode;
- the absence of stale words after power-down.

// File: rtl/pixin_pkg.sv
package pixin_pkg;
  parameter int PIX_W = 24;
  parameter int GP_W  = 3;

  typedef struct packed {
    logic            de;
    logic            hs;
    logic            vs;
    logic [GP_W-1:0] gp;
  } ctl_t;

  typedef struct packed {
    logic [PIX_W-1:0] px_a;
    logic [PIX_W-1:0] px_b;
    ctl_t             ctl;
  } word_t;

  typedef struct packed {
    logic [PIX_W-1:0] px;
    ctl_t             ctl;
  } beat_t;

  localparam beat_t BEAT_IDLE = '0;
endpackage

// File: rtl/pixin_edge_bank.sv
module pixin_edge_bank
  import pixin_pkg::*;
#(
  parameter bit FALLING = 1'b0
) (
  input  logic  clk_in,
  input  logic  rst_n,
  input  logic  cap_en,
  input  word_t word_d,
  output word_t word_q,
  output logic  tog_q
);
  word_t word_nxt;
  logic  tog_nxt;

  always_comb begin
    word_nxt = word_q;
    tog_nxt  = tog_q;
    if (cap_en) begin
      word_nxt = word_d;
      tog_nxt  = ~tog_q;
    end
  end

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
          tog_q  <= 1'b0;
        end else begin
          word_q <= word_nxt;
          tog_q  <= tog_nxt;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
          tog_q  <= 1'b0;
        end else begin
          word_q <= word_nxt;
          tog_q  <= tog_nxt;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pixin_retime.sv
module pixin_retime
  import pixin_pkg::*;
(
  input  logic  clk_pix,
  input  logic  rst_n,
  input  logic  pd_n,
  input  word_t word_in,
  input  logic  tog_in,
  output word_t word_q,
  output logic  fresh_q
);
  logic  seen_q, seen_nxt, fresh_nxt;
  word_t word_nxt;

  always_comb begin
    seen_nxt  = tog_in;
    fresh_nxt = pd_n && (tog_in != seen_q);
    word_nxt  = fresh_nxt ? word_in : word_q;
  end

  always_ff @(posedge clk_pix or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      fresh_q <= 1'b0;
      word_q  <= '0;
    end else begin
      seen_q  <= seen_nxt;
      fresh_q <= fresh_nxt;
      word_q  <= word_nxt;
    end
  end
endmodule

// File: rtl/pixin_serializer.sv
module pixin_serializer
  import pixin_pkg::*;
(
  input  logic  clk_pix,
  input  logic  rst_n,
  input  logic  pd_n,
  input  logic  dual_px,
  input  logic  fresh,
  input  word_t word,
  output beat_t beat_q
);
  beat_t beat_nxt;
  logic  pend_q, pend_nxt;

  always_comb begin
    beat_nxt = BEAT_IDLE;
    pend_nxt = 1'b0;
    if (pd_n) begin
      if (fresh) begin
        beat_nxt.px  = word.px_a;
        beat_nxt.ctl = word.ctl;
        pend_nxt     = dual_px;
      end else if (pend_q) begin
        beat_nxt.px  = word.px_b;
        beat_nxt.ctl = word.ctl;
      end
    end
  end

  always_ff @(posedge clk_pix or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= BEAT_IDLE;
      pend_q <= 1'b0;
    end else begin
      beat_q <= beat_nxt;
      pend_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/pixin_capture.sv
module pixin_capture
  import pixin_pkg::*;
(
  input  logic             clk_in,
  input  logic             clk_pix,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             edge_rise,
  input  logic             dual_px,
  input  logic [PIX_W-1:0] px_first,
  input  logic [PIX_W-1:0] px_second,
  input  logic             de_in,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic [GP_W-1:0]  ctl_in,
  output logic [PIX_W-1:0] px_out,
  output logic             de_out,
  output logic             hs_out,
  output logic             vs_out,
  output logic [GP_W-1:0]  ctl_out
);
  word_t word_in, word_r, word_f, word_sel, word_rt;
  logic  tog_r, tog_f, tog_sel, fresh_w;
  beat_t beat;

  always_comb begin
    word_in.px_a   = px_first;
    word_in.px_b   = px_second;
    word_in.ctl.de = de_in;
    word_in.ctl.hs = hs_in;
    word_in.ctl.vs = vs_in;
    word_in.ctl.gp = ctl_in;
    word_sel       = edge_rise ? word_r : word_f;
    tog_sel        = edge_rise ? tog_r  : tog_f;
  end

  pixin_edge_bank #(.FALLING(1'b0)) u_bank_rise (
    .clk_in(clk_in), .rst_n(rst_n), .cap_en(pd_n & edge_rise),
    .word_d(word_in), .word_q(word_r), .tog_q(tog_r)
  );

  pixin_edge_bank #(.FALLING(1'b1)) u_bank_fall (
    .clk_in(clk_in), .rst_n(rst_n), .cap_en(pd_n & ~edge_rise),
    .word_d(word_in), .word_q(word_f), .tog_q(tog_f)
  );

  pixin_retime u_retime (
    .clk_pix(clk_pix), .rst_n(rst_n), .pd_n(pd_n),
    .word_in(word_sel), .tog_in(tog_sel),
    .word_q(word_rt), .fresh_q(fresh_w)
  );

  pixin_serializer u_ser (
    .clk_pix(clk_pix), .rst_n(rst_n), .pd_n(pd_n), .dual_px(dual_px),
    .fresh(fresh_w), .word(word_rt), .beat_q(beat)
  );

  assign px_out  = beat.px;
  assign de_out  = beat.ctl.de;
  assign hs_out  = beat.ctl.hs;
  assign vs_out  = beat.ctl.vs;
  assign ctl_out = beat.ctl.gp;
endmodule

// File: rtl/pixin_capture_chk.sv
module pixin_capture_chk
  import pixin_pkg::*;
(
  input logic             clk_pix,
  input logic             rst_n,
  input logic             pd_n,
  input logic             dual_px,
  input logic             fresh,
  input logic [PIX_W-1:0] px_out,
  input logic             de_out,
  input logic             hs_out,
  input logic             vs_out,
  input logic [GP_W-1:0]  ctl_out
);
  assert_pd_idle_R7: assert property (@(posedge clk_pix) disable iff (!rst_n)
    !pd_n |=> (!de_out && !hs_out && !vs_out && ctl_out == '0 && px_out == '0));

  assert_pair_ctl_R6: assert property (@(posedge clk_pix) disable iff (!rst_n)
    (pd_n && dual_px && fresh) ##1 pd_n |=> $stable({de_out, hs_out, vs_out, ctl_out}));

  assert_dual_spacing_R5: assert property (@(posedge clk_pix) disable iff (!rst_n)
    (pd_n && dual_px && fresh) |=> !fresh);

  assert_de_backed_R8: assert property (@(posedge clk_pix) disable iff (!rst_n)
    de_out |-> ($past(fresh) || (dual_px && $past(fresh, 2))));
endmodule

bind pixin_capture pixin_capture_chk u_chk (
  .clk_pix(clk_pix), .rst_n(rst_n), .pd_n(pd_n), .dual_px(dual_px),
  .fresh(fresh_w), .px_out(px_out), .de_out(de_out), .hs_out(hs_out),
  .vs_out(vs_out), .ctl_out(ctl_out)
);

// File: tb/pixin_capture_bench.sv
module pixin_capture_bench;
  logic        clk_in, clk_pix, rst_n, pd_n, edge_rise, dual_px;
  logic [23:0] px_first, px_second, px_out;
  logic        de_in, hs_in, vs_in, de_out, hs_out, vs_out;
  logic [2:0]  ctl_in, ctl_out;

  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic        mon_en = 1'b0;
  int          due_q[$];
  logic [29:0] exp_q[$];
  string       tag_q[$];

  pixin_capture u_pixin_capture (
    .clk_in(clk_in), .clk_pix(clk_pix), .rst_n(rst_n), .pd_n(pd_n),
    .edge_rise(edge_rise), .dual_px(dual_px), .px_first(px_first),
    .px_second(px_second), .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in),
    .ctl_in(ctl_in), .px_out(px_out), .de_out(de_out), .hs_out(hs_out),
    .vs_out(vs_out), .ctl_out(ctl_out)
  );

  // 100 MHz pixel clock; input clock equal or half rate, rising edges aligned
  initial begin
    clk_pix = 1'b0;
    clk_in  = 1'b0;
    forever begin
      #5;
      clk_pix = ~clk_pix;
      if (!dual_px) clk_in = clk_pix;
      else if (clk_pix) clk_in = ~clk_in;
    end
  end

  always @(posedge clk_pix) cyc <= cyc + 1;

  function automatic logic [29:0] out_vec();
    return {px_out, de_out, hs_out, vs_out, ctl_out};
  endfunction

  task automatic check(input string tag, input logic [29:0] act, input logic [29:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_pix) begin
    if (mon_en) begin
      while (due_q.size() > 0 && due_q[0] < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s cycle %0d: actual=missing expected=%h", tag_q[0], cyc, exp_q[0]);
        void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        check(tag_q[0], out_vec(), exp_q[0]);
        void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end else begin
        check(pd_n ? "R8 idle" : "R7 idle", out_vec(), 30'h0);
      end
    end
  end

  task automatic cap_wait();
    if (edge_rise) @(posedge clk_in);
    else @(negedge clk_in);
    #1;
  endtask

  task automatic send(input logic [23:0] a, input logic [23:0] b, input logic de,
                      input logic hs, input logic vs, input logic [2:0] g, input string tag);
    px_first = a; px_second = b; de_in = de; hs_in = hs; vs_in = vs; ctl_in = g;
    cap_wait();
    due_q.push_back(cyc + 2); exp_q.push_back({a, de, hs, vs, g}); tag_q.push_back(tag);
    if (dual_px) begin
      due_q.push_back(cyc + 3); exp_q.push_back({b, de, hs, vs, g}); tag_q.push_back(tag);
    end
  endtask

  task automatic power_down();
    pd_n = 1'b0;
    while (due_q.size() > 0 && due_q[$] > cyc) begin
      void'(due_q.pop_back()); void'(exp_q.pop_back()); void'(tag_q.pop_back());
    end
    // bait values that must never appear after release (R8)
    px_first = 24'hABCDEF; px_second = 24'h123456; de_in = 1'b1;
    hs_in = 1'b1; vs_in = 1'b1; ctl_in = 3'b111;
    repeat (4) cap_wait();
  endtask

  task automatic reconfig(input logic new_edge, input logic new_dual);
    power_down();
    edge_rise = new_edge;
    dual_px   = new_dual;
    repeat (4) cap_wait();
    pd_n = 1'b1;
  endtask

  task automatic burst(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic de;
      de = (i % 8) < 5;  // blanking stretch every eight words (R10)
      send($urandom(), $urandom(), de, $urandom_range(0, 1), $urandom_range(0, 1),
           3'($urandom_range(0, 7)), tag);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pd_n = 1'b0; edge_rise = 1'b1; dual_px = 1'b0;
    px_first = 24'hFFFFFF; px_second = 24'hFFFFFF;
    de_in = 1'b1; hs_in = 1'b1; vs_in = 1'b1; ctl_in = 3'b111;
    repeat (3) @(negedge clk_pix);
    check("R9 reset", out_vec(), 30'h0);
    #3 rst_n = 1'b1;
    repeat (2) @(negedge clk_pix);
    check("R9 after release", out_vec(), 30'h0);
    mon_en = 1'b1;
    cap_wait();
    pd_n = 1'b1;

    burst(40, "R1 R3 R4 R10 rise single");
    send(24'h000001, 24'hFFFFFF, 1'b1, 1'b0, 1'b0, 3'b000, "R4 second ignored");
    send(24'h000002, 24'h000000, 1'b1, 1'b0, 1'b0, 3'b000, "R4 second ignored");
    reconfig(1'b0, 1'b0);
    burst(40, "R2 R3 R4 R10 fall single");
    reconfig(1'b1, 1'b1);
    burst(40, "R1 R3 R5 R6 rise dual");
    send(24'h111111, 24'h222222, 1'b0, 1'b1, 1'b0, 3'b101, "R5 R6 R10 blank pair");
    reconfig(1'b0, 1'b1);
    burst(40, "R2 R3 R5 R6 fall dual");
    reconfig(1'b1, 1'b0);
    burst(10, "R8 first words after release");
    power_down();
    repeat (6) @(negedge clk_pix);
    check("R3 queue drained", 30'(due_q.size()), 30'h0);
    mon_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule